// File: doc/BRIEF.md
# Write-Through Invalidate Snoop Controller

This block is the coherence controller of one node's small direct-mapped, write-through cache on a shared broadcast bus. Each line is either Valid or Invalid. Processor reads that hit a Valid line are answered locally. A read miss fetches the word over the bus. Every processor write, hit or miss, is sent to memory as a bus write. Several nodes may therefore hold the same line Valid for reading. A write seen on the bus from another node to a line held here kills the local copy.

The controller asks an external arbiter for the bus with a request/grant pair. It changes no line for a write until the grant is held, so the bus order fixes the order of writes. Every bus transaction carries a source node number. The snoop port watches every transaction and ignores the ones this node issued. When a snoop and a processor access fall on the same line index in the same cycle, the snoop wins and the processor access waits one cycle. The memory model and the arbiter are outside the block.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `bus_req`, `cpu_done` and `out_valid` are low, so the first read of any address is a miss.
- R2: A read miss raises `bus_req` in the cycle after the request is taken. In the cycle `bus_gnt` is high it drives `out_valid`=1, `out_we`=0, `out_addr`=address and `out_src`=NODE_ID. In the cycle after `mem_rvalid` it raises `cpu_done` with `cpu_rdata`=`mem_rdata`. The line then holds that word Valid.
- R3: Every write, hit or miss, takes the bus. In the grant cycle it drives `out_valid`=1, `out_we`=1, `out_addr`, `out_data`=write data and `out_src`=NODE_ID. It raises `cpu_done` one cycle later. The line then holds the written word Valid, which allocates on a miss.
- R4: A bus write from another node (`snp_src`≠NODE_ID) whose address matches a Valid line's index and tag makes that line Invalid. The next read of that address misses.
- R5: A foreign bus read never invalidates, so copies stay shared. A foreign write to the same index with a different tag leaves the held line Valid.
- R6: A write finishes only after it holds the grant. While `bus_gnt` stays low, `out_valid` and `cpu_done` stay low.
- R7: A read hit raises `cpu_done` in the cycle after the request is taken and returns the cached word. `bus_req` does not rise.
- R8: A foreign snoop (read or write) whose line index (address bits [IW-1:0]) equals the index of a waiting processor request stalls that request by exactly one cycle. A snoop to another index adds no delay.
- R9: Transactions on the snoop port that carry this node's own number are ignored and never invalidate a line.
- R10: `cpu_done` is a one-cycle pulse. The processor holds `cpu_req` and its operands until it sees `cpu_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | DW | Processor write data |
| cpu_rdata | output | DW | Read result, valid with cpu_done |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| out_valid | output | 1 | This node drives a bus transaction this cycle |
| out_we | output | 1 | Transaction kind, 1 = write |
| out_addr | output | AW | Transaction address |
| out_data | output | DW | Write data of the transaction |
| out_src | output | NODE_W | Source number, equal to NODE_ID |
| mem_rvalid | input | 1 | Memory read data strobe |
| mem_rdata | input | DW | Memory read data |
| snp_valid | input | 1 | A transaction is on the shared bus |
| snp_we | input | 1 | Observed transaction is a write |
| snp_addr | input | AW | Observed address |
| snp_src | input | NODE_W | Observed source number |

## Verification
A read hit completes one edge after the request is taken, or two when a same-index snoop collides. A write completes one edge after the grant cycle. A read miss raises `bus_req` one edge after acceptance and completes one edge after `mem_rvalid`. The bench drives inputs on the falling edge and samples one falling edge after the edge where each result is due. It looks for the combinational bus drive 1 ns after raising the grant. A reference model of line states and of the expected `bus_req` is updated just after each rising edge and compared on every falling edge.

// File: rtl/wtsn_pkg.sv
package wtsn_pkg;
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_ARB  = 2'd1,
    PS_FILL = 2'd2
  } pstate_t;
endpackage

// File: rtl/wt_line_store.sv
module wt_line_store #(
  parameter int IW    = 3,
  parameter int TW    = 9,
  parameter int DW    = 16,
  parameter int LINES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_valid,
  output logic [TW-1:0] rd_tag,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [TW-1:0] wr_tag,
  input  logic [DW-1:0] wr_data,
  input  logic          snp_chk,
  input  logic [IW-1:0] snp_idx,
  input  logic [TW-1:0] snp_tag,
  output logic          snp_inv
);
  logic [LINES-1:0] valid_q;
  logic [TW-1:0]    tag_q  [LINES];
  logic [DW-1:0]    data_q [LINES];

  // snoop tag compare: a hit on a Valid line kills it
  assign snp_inv  = snp_chk && valid_q[snp_idx] && (tag_q[snp_idx] == snp_tag);
  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
        if (!rst_n)                                valid_q[g] <= 1'b0;
        else if (snp_inv && snp_idx == IW'(g))     valid_q[g] <= 1'b0;
        else if (wr_en && wr_idx == IW'(g))        valid_q[g] <= 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  // R4
  snoop_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_inv |=> !valid_q[$past(snp_idx)]);

  // R2
  line_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(snp_inv && snp_idx == wr_idx)) |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/wt_req_fsm.sv
module wt_req_fsm
  import wtsn_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic          cpu_hit,
  input  logic          collide,
  input  logic          bus_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] rd_data,
  input  logic [DW-1:0] mem_rdata,
  output logic          bus_req,
  output logic          issue,
  output logic          line_wr,
  output logic          line_fill,
  output logic          cpu_done,
  output logic [DW-1:0] cpu_rdata
);
  pstate_t state_q, state_d;
  logic    accept, hit_rd, go_bus, fill_end, wr_end;

  assign accept    = (state_q == PS_IDLE) && cpu_req && !cpu_done && !collide;
  assign hit_rd    = accept && !cpu_we && cpu_hit;
  assign go_bus    = accept && !hit_rd;
  assign bus_req   = (state_q == PS_ARB);
  assign issue     = bus_req && bus_gnt;
  assign wr_end    = issue && cpu_we;
  assign line_fill = (state_q == PS_FILL);
  assign fill_end  = line_fill && mem_rvalid;
  assign line_wr   = wr_end || fill_end;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE: if (go_bus)     state_d = PS_ARB;
      PS_ARB:  if (issue)      state_d = cpu_we ? PS_IDLE : PS_FILL;
      PS_FILL: if (mem_rvalid) state_d = PS_IDLE;
      default:                 state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= PS_IDLE;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      state_q  <= state_d;
      cpu_done <= hit_rd || wr_end || fill_end;
      if (hit_rd)        cpu_rdata <= rd_data;
      else if (fill_end) cpu_rdata <= mem_rdata;
    end
  end

  // R7
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rd |=> (cpu_done && !bus_req));

  // R8
  collide_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_IDLE && cpu_req && !cpu_done && collide) |=> !cpu_done);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
endmodule

// File: rtl/wt_snoop_ctrl.sv
module wt_snoop_ctrl #(
  parameter int AW      = 12,
  parameter int DW      = 16,
  parameter int LINES   = 8,
  parameter int NODE_W  = 2,
  parameter int NODE_ID = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  output logic              cpu_done,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              out_valid,
  output logic              out_we,
  output logic [AW-1:0]     out_addr,
  output logic [DW-1:0]     out_data,
  output logic [NODE_W-1:0] out_src,
  input  logic              mem_rvalid,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              snp_valid,
  input  logic              snp_we,
  input  logic [AW-1:0]     snp_addr,
  input  logic [NODE_W-1:0] snp_src
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;
  localparam logic [NODE_W-1:0] MY_ID = NODE_W'(NODE_ID);

  function automatic logic [IW-1:0] line_of(input logic [AW-1:0] a);
    return a[IW-1:0];
  endfunction

  function automatic logic [TW-1:0] tag_of(input logic [AW-1:0] a);
    return a[AW-1:IW];
  endfunction

  logic [IW-1:0] cpu_idx, snp_idx;
  logic [TW-1:0] cpu_tag, snp_tag, rd_tag;
  logic [DW-1:0] rd_data, wr_data;
  logic          rd_valid, cpu_hit, foreign_snp, snp_collide, snp_chk, snp_inv;
  logic          issue, line_wr, line_fill;

  assign cpu_idx     = line_of(cpu_addr);
  assign cpu_tag     = tag_of(cpu_addr);
  assign snp_idx     = line_of(snp_addr);
  assign snp_tag     = tag_of(snp_addr);
  assign foreign_snp = snp_valid && (snp_src != MY_ID);
  assign snp_collide = foreign_snp && (snp_idx == cpu_idx);
  assign snp_chk     = foreign_snp && snp_we;
  assign cpu_hit     = rd_valid && (rd_tag == cpu_tag);
  assign wr_data     = line_fill ? mem_rdata : cpu_wdata;

  assign out_valid = issue;
  assign out_we    = cpu_we;
  assign out_addr  = cpu_addr;
  assign out_data  = cpu_wdata;
  assign out_src   = MY_ID;

  wt_line_store #(.IW(IW), .TW(TW), .DW(DW), .LINES(LINES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(cpu_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data),
    .wr_en(line_wr), .wr_idx(cpu_idx), .wr_tag(cpu_tag), .wr_data(wr_data),
    .snp_chk(snp_chk), .snp_idx(snp_idx), .snp_tag(snp_tag), .snp_inv(snp_inv)
  );

  wt_req_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_hit(cpu_hit), .collide(snp_collide),
    .bus_gnt(bus_gnt), .mem_rvalid(mem_rvalid), .rd_data(rd_data), .mem_rdata(mem_rdata),
    .bus_req(bus_req), .issue(issue), .line_wr(line_wr), .line_fill(line_fill),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata)
  );

  // R9
  own_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_src == MY_ID) |-> !snp_inv);

  // R6
  wr_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && cpu_we) |-> $past(bus_gnt));

  // R3
  out_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !bus_req);
endmodule

// File: tb/test_wt_snoop_ctrl.sv
`timescale 1ns/1ps
module test_wt_snoop_ctrl;
  localparam int AW = 12, DW = 16, LINES = 8, NW = 2, ID = 1;
  localparam int IW = $clog2(LINES);

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_done, bus_req, bus_gnt = 0, out_valid, out_we;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;
  logic [NW-1:0] out_src;
  logic mem_rvalid = 0;
  logic [DW-1:0] mem_rdata = '0;
  logic snp_valid = 0, snp_we = 0;
  logic [AW-1:0] snp_addr = '0;
  logic [NW-1:0] snp_src = '0;

  int tests = 0, fails = 0;
  bit finished = 0;
  bit m_breq = 0;
  bit m_val [LINES];
  int m_tag [LINES];
  int m_dat [LINES];

  always #4 clk = ~clk;

  wt_snoop_ctrl #(.AW(AW), .DW(DW), .LINES(LINES), .NODE_W(NW), .NODE_ID(ID)) i_wt_snoop_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .out_valid(out_valid), .out_we(out_we),
    .out_addr(out_addr), .out_data(out_data), .out_src(out_src),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .snp_valid(snp_valid),
    .snp_we(snp_we), .snp_addr(snp_addr), .snp_src(snp_src)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int idx(input int a); return a % LINES; endfunction
  function automatic int tg(input int a);  return a / LINES; endfunction
  function automatic bit holds(input int a);
    return m_val[idx(a)] && m_tag[idx(a)] == tg(a);
  endfunction

  // reference: expected bus_req compared every falling edge
  always @(negedge clk) if (rst_n && !finished) begin
    if (bus_req !== m_breq) check(0, "R2 bus_req", bus_req, m_breq);
  end

  task automatic cpu_op(input bit we, input int a, input int wd, input int gwait, input int mword);
    bit hit;
    hit = !we && holds(a);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = DW'(wd);
    if (hit) begin
      @(negedge clk);
      check(cpu_done === 1'b1, "R7 hit done", cpu_done, 1);
      check(cpu_rdata == DW'(m_dat[idx(a)]), "R7 hit data", cpu_rdata, m_dat[idx(a)]);
    end else begin
      @(posedge clk); #1 m_breq = 1;
      for (int k = 0; k < gwait; k++) begin
        @(negedge clk);
        check(out_valid === 1'b0 && cpu_done === 1'b0, "R6 wait grant", {out_valid, cpu_done}, 0);
      end
      @(negedge clk); bus_gnt = 1; #1;
      check(out_valid === 1'b1 && out_we === we && out_addr == AW'(a) && out_src == NW'(ID),
            we ? "R3 bus write" : "R2 bus read", {out_valid, out_we, out_addr}, {1'b1, we, AW'(a)});
      if (we) check(out_data == DW'(wd), "R3 bus data", out_data, wd);
      @(posedge clk); #1 m_breq = 0;
      @(negedge clk); bus_gnt = 0;
      if (we) begin
        check(cpu_done === 1'b1, "R3 write done", cpu_done, 1);
        m_val[idx(a)] = 1; m_tag[idx(a)] = tg(a); m_dat[idx(a)] = wd;
      end else begin
        check(cpu_done === 1'b0, "R2 wait mem", cpu_done, 0);
        mem_rvalid = 1; mem_rdata = DW'(mword);
        @(negedge clk); mem_rvalid = 0;
        check(cpu_done === 1'b1 && cpu_rdata == DW'(mword), "R2 fill data", cpu_rdata, mword);
        m_val[idx(a)] = 1; m_tag[idx(a)] = tg(a); m_dat[idx(a)] = mword;
      end
    end
    cpu_req = 0;
    @(negedge clk);
    check(cpu_done === 1'b0, "R10 pulse", cpu_done, 0);
  endtask

  task automatic snoop(input bit we, input int a, input int src);
    @(negedge clk);
    snp_valid = 1; snp_we = we; snp_addr = AW'(a); snp_src = NW'(src);
    @(posedge clk); #1;
    if (we && src != ID && holds(a)) m_val[idx(a)] = 0;
    @(negedge clk); snp_valid = 0;
  endtask

  task automatic expect_hit(input int a, input string req);
    check(holds(a), req, 0, 1);
    cpu_op(0, a, 0, 0, 0);
  endtask

  localparam int A = 'h010, B = 'h023, C = 'h0A0;

  initial begin
    for (int i = 0; i < LINES; i++) begin m_val[i] = 0; m_tag[i] = 0; m_dat[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(bus_req === 0 && cpu_done === 0 && out_valid === 0, "R1 reset outputs",
          {bus_req, cpu_done, out_valid}, 0);
    // R1 / R2: first read misses
    cpu_op(0, A, 0, 2, 'h1234);
    // R7
    cpu_op(0, A, 0, 0, 0);
    // R3 write hit, then R3 write miss with slow grant (R6)
    cpu_op(1, A, 'h5555, 0, 0);
    expect_hit(A, "R3 hit after write");
    cpu_op(1, B, 'h0BBB, 3, 0);
    expect_hit(B, "R3 allocate");
    // R5 foreign read keeps copy
    snoop(0, A, 2);
    expect_hit(A, "R5 shared read");
    // R5 same index, other tag
    snoop(1, C, 2);
    expect_hit(A, "R5 other tag");
    // R9 own source ignored
    snoop(1, A, ID);
    expect_hit(A, "R9 own write");
    // R4 foreign write kills
    snoop(1, A, 0);
    check(!holds(A), "R4 model", 0, 0);
    cpu_op(0, A, 0, 1, 'h7777);
    // R8 collision stall
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = AW'(B);
    snp_valid = 1; snp_we = 0; snp_addr = AW'(B + LINES); snp_src = 2;
    @(negedge clk); snp_valid = 0;
    check(cpu_done === 1'b0, "R8 stall", cpu_done, 0);
    @(negedge clk);
    check(cpu_done === 1'b1 && cpu_rdata == DW'('h0BBB), "R8 after stall", cpu_rdata, 'h0BBB);
    cpu_req = 0;
    @(negedge clk);
    // R8 no stall on other index
    cpu_req = 1; cpu_addr = AW'(A);
    snp_valid = 1; snp_we = 0; snp_addr = AW'(B); snp_src = 2;
    @(negedge clk); snp_valid = 0;
    check(cpu_done === 1'b1 && cpu_rdata == DW'('h7777), "R8 no stall", cpu_rdata, 'h7777);
    cpu_req = 0;
    @(negedge clk);
    // conflict replacement: C evicts A
    cpu_op(0, C, 0, 0, 'h0C0C);
    expect_hit(C, "R2 replaced line");
    cpu_op(0, A, 0, 0, 'h7777);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule